// File: doc/BRIEF.md
# PCI Configuration Cycle Address Generator

This block accepts one configuration-space request at a time. A request carries a bus number, a device/function byte, a register offset, an access size and a direction. The block checks the request and builds the configuration address. A request on bus 0 gets a type 0 address with a one-hot device select. A request on any other bus gets a type 1 address. The configuration address is then packed into a sparse host address, and the block runs a single strobe/acknowledge cycle on the host side.

A type 1 cycle needs a different mode in a shared extension register. Before the cycle, the block captures that register with its two mode bits cleared and writes it back with the mode set to type 1. After the cycle it writes the captured value back.

Every accepted cycle is followed by a fixed error-observation window. The window length is a parameter given in clock cycles. An abort seen from the strobe to the end of the window turns read data into all-ones and is reported with the response. Read data is right-aligned from its byte lane. Write data is moved up into its byte lane.

Top module: `pcicfg_cyc_gen`

## Requirements
- R1: With bus number 0, the configuration address has bit (11 + device) set as the only select bit in bits 23:11, the function (devfn bits 2:0) in bits 10:8 and the offset in bits 7:0; `cyc_type1_o` is 0.
- R2: A bus-0 request whose device number (devfn bits 7:3) exceeds MAX_DEV (8) is answered with `rsp_err_o`=1, `rsp_abort_o`=0 and read data 0. No strobe and no extension-register write occur.
- R3: With a nonzero bus number, the configuration address is {bus, devfn, offset} in bits 23:0 and `cyc_type1_o` is 1.
- R4: An access size other than 1, 2 or 4 is answered with `rsp_err_o`=1 and no strobe or extension write, whatever the bus.
- R5: `cyc_addr_o` equals configuration address × 32 + (size − 1) × 8 + CFG_BASE, truncated to HOST_W bits.
- R6: Returned read data is the captured bus data shifted right by (offset mod 4) × 8. `cyc_wdata_o` is the request data shifted left by the same amount, truncated to 32 bits. Read data of a write response is 0.
- R7: Before the strobe of a type 1 cycle, exactly one extension write occurs, with value (captured value with bits 31:30 cleared) with bits 31:30 set to 01. Type 0 and rejected requests cause no extension write.
- R8: After the window of a type 1 cycle, one extension write restores the captured value with bits 31:30 cleared, in the cycle after the window ends.
- R9: An abort input high in the strobe cycle or in any window cycle makes `rsp_abort_o`=1 and, on reads, the returned data 0xFFFFFFFF. An abort outside those cycles has no effect.
- R10: The window lasts WAIT_CYCLES cycles after the acknowledged strobe cycle. `ack_o` rises WAIT_CYCLES+1 cycles after the strobe cycle for type 0 and WAIT_CYCLES+2 cycles after it for type 1.
- R11: After reset, `busy_o`, `ack_o`, `cyc_stb_o` and `ext_we_o` are 0. `busy_o` stays high from acceptance through the one-cycle `ack_o` and is low the cycle after. Request inputs changed while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request; accepted when not busy |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Bus number |
| req_devfn_i | input | 8 | Device (7:3) and function (2:0) |
| req_off_i | input | 8 | Register byte offset |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data, right-aligned |
| busy_o | output | 1 | Request in progress |
| ack_o | output | 1 | One-cycle response strobe |
| rsp_err_o | output | 1 | Request rejected (valid with ack_o) |
| rsp_abort_o | output | 1 | Abort observed (valid with ack_o) |
| rsp_rdata_o | output | 32 | Aligned read data (valid with ack_o) |
| cyc_stb_o | output | 1 | Host cycle strobe, held until cyc_ack_i |
| cyc_ack_i | input | 1 | Host cycle acknowledge |
| cyc_type1_o | output | 1 | Current cycle is type 1 |
| cyc_write_o | output | 1 | Current cycle is a write |
| cyc_addr_o | output | HOST_W | Sparse host address |
| cyc_wdata_o | output | 32 | Lane-shifted write data |
| cyc_rdata_i | input | 32 | Read data, captured with cyc_ack_i |
| cyc_abort_i | input | 1 | Target abort / error report |
| ext_rdata_i | input | 32 | Current extension register value |
| ext_we_o | output | 1 | Extension register write enable |
| ext_wdata_o | output | 32 | Extension register write value |

## Verification
Two of the block's functions can fall in the same cycle. One is abort sampling. The other is the end of the observation window together with the start of the extension restore write. The bench raises the abort exactly in the last window cycle and expects all-ones read data with the restore write still on time. It raises the abort one cycle later, in the restore cycle, and expects no abort. It also raises the abort in the same cycle as the strobe acknowledge, so data capture and abort sampling coincide, and expects the abort to win over the captured data.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

    localparam int CFG_DATA_W  = 32;
    localparam int CFG_ADDR_W  = 24;
    localparam int MODE_LSB    = 30;
    localparam logic [1:0] MODE_TYPE1 = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_MODE,
        ST_ISSUE,
        ST_WINDOW,
        ST_RESTORE,
        ST_RESP
    } seq_state_e;

endpackage

// File: rtl/pcicfg_addr_form.sv
module pcicfg_addr_form #(
    parameter int          HOST_W   = 40,
    parameter logic [63:0] CFG_BASE = 64'h38_0000_0000,
    parameter int          MAX_DEV  = 8
) (
    input  logic [7:0]        bus_i,
    input  logic [7:0]        devfn_i,
    input  logic [7:0]        off_i,
    input  logic [2:0]        size_i,
    output logic              type1_o,
    output logic              reject_o,
    output logic [HOST_W-1:0] host_o
);
    import pcicfg_pkg::*;

    localparam int SPARSE_SH = 5;
    localparam int SEL_LSB   = 11;
    localparam int PAD_W     = CFG_ADDR_W - SEL_LSB;

    logic [4:0]            dev;
    logic [2:0]            fn;
    logic [CFG_ADDR_W-1:0] t0_addr;
    logic [CFG_ADDR_W-1:0] t1_addr;
    logic [CFG_ADDR_W-1:0] cfg_addr;
    logic                  size_ok;
    logic                  dev_ok;
    logic [HOST_W-1:0]     size_code;

    always_comb begin
        dev      = devfn_i[7:3];
        fn       = devfn_i[2:0];
        type1_o  = |bus_i;
        size_ok  = (size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4);
        dev_ok   = type1_o || (int'(dev) <= MAX_DEV);
        reject_o = !size_ok || !dev_ok;
        t0_addr  = (CFG_ADDR_W'(1) << (SEL_LSB + int'(dev))) | {{PAD_W{1'b0}}, fn, off_i};
        t1_addr  = {bus_i, devfn_i, off_i};
        cfg_addr = type1_o ? t1_addr : t0_addr;
        size_code = HOST_W'({size_i - 3'd1, 3'b000});
        host_o   = (HOST_W'(cfg_addr) << SPARSE_SH) + size_code + HOST_W'(CFG_BASE);
    end

endmodule

// File: rtl/pcicfg_lane.sv
module pcicfg_lane #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        off_lo_i,
    input  logic [DATA_W-1:0] rd_raw_i,
    input  logic [DATA_W-1:0] wr_raw_i,
    input  logic              abort_i,
    input  logic              quiet_i,
    output logic [DATA_W-1:0] rd_o,
    output logic [DATA_W-1:0] wr_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] sh;

    always_comb begin
        sh = SH_W'({off_lo_i, 3'b000});
        if (quiet_i)      rd_o = '0;
        else if (abort_i) rd_o = '1;
        else              rd_o = rd_raw_i >> sh;
        wr_o = wr_raw_i << sh;
    end

endmodule

// File: rtl/pcicfg_cyc_gen.sv
module pcicfg_cyc_gen #(
    parameter int          HOST_W      = 40,
    parameter logic [63:0] CFG_BASE    = 64'h38_0000_0000,
    parameter int          MAX_DEV     = 8,
    parameter int          WAIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_write_i,
    input  logic [7:0]        req_bus_i,
    input  logic [7:0]        req_devfn_i,
    input  logic [7:0]        req_off_i,
    input  logic [2:0]        req_size_i,
    input  logic [31:0]       req_wdata_i,
    output logic              busy_o,
    output logic              ack_o,
    output logic              rsp_err_o,
    output logic              rsp_abort_o,
    output logic [31:0]       rsp_rdata_o,
    output logic              cyc_stb_o,
    input  logic              cyc_ack_i,
    output logic              cyc_type1_o,
    output logic              cyc_write_o,
    output logic [HOST_W-1:0] cyc_addr_o,
    output logic [31:0]       cyc_wdata_o,
    input  logic [31:0]       cyc_rdata_i,
    input  logic              cyc_abort_i,
    input  logic [31:0]       ext_rdata_i,
    output logic              ext_we_o,
    output logic [31:0]       ext_wdata_o
);
    import pcicfg_pkg::*;

    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam int DW    = CFG_DATA_W;

    typedef struct packed {
        seq_state_e       st;
        logic             wr;
        logic [7:0]       bus;
        logic [7:0]       devfn;
        logic [7:0]       off;
        logic [2:0]       size;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    saved;
        logic [DW-1:0]    rdata;
        logic             abort;
        logic             reject;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    logic type1_w;
    logic reject_w;
    logic quiet_w;

    pcicfg_addr_form #(
        .HOST_W   (HOST_W),
        .CFG_BASE (CFG_BASE),
        .MAX_DEV  (MAX_DEV)
    ) u_addr (
        .bus_i    (s_q.bus),
        .devfn_i  (s_q.devfn),
        .off_i    (s_q.off),
        .size_i   (s_q.size),
        .type1_o  (type1_w),
        .reject_o (reject_w),
        .host_o   (cyc_addr_o)
    );

    assign quiet_w = s_q.wr || s_q.reject;

    pcicfg_lane #(.DATA_W(DW)) u_lane (
        .off_lo_i (s_q.off[1:0]),
        .rd_raw_i (s_q.rdata),
        .wr_raw_i (s_q.wdata),
        .abort_i  (s_q.abort),
        .quiet_i  (quiet_w),
        .rd_o     (rsp_rdata_o),
        .wr_o     (cyc_wdata_o)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    s_d.wr     = req_write_i;
                    s_d.bus    = req_bus_i;
                    s_d.devfn  = req_devfn_i;
                    s_d.off    = req_off_i;
                    s_d.size   = req_size_i;
                    s_d.wdata  = req_wdata_i;
                    s_d.rdata  = '0;
                    s_d.abort  = 1'b0;
                    s_d.reject = 1'b0;
                    s_d.st     = ST_CHECK;
                end
            end
            ST_CHECK: begin
                s_d.reject = reject_w;
                s_d.saved  = ext_rdata_i & ~({2'b11, {(DW-2){1'b0}}});
                if (reject_w)     s_d.st = ST_RESP;
                else if (type1_w) s_d.st = ST_MODE;
                else              s_d.st = ST_ISSUE;
            end
            ST_MODE: s_d.st = ST_ISSUE;
            ST_ISSUE: begin
                if (cyc_abort_i) s_d.abort = 1'b1;
                if (cyc_ack_i) begin
                    s_d.rdata = cyc_rdata_i;
                    s_d.cnt   = CNT_W'(WAIT_CYCLES - 1);
                    s_d.st    = ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (cyc_abort_i) s_d.abort = 1'b1;
                if (s_q.cnt == '0) s_d.st = type1_w ? ST_RESTORE : ST_RESP;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_RESTORE: s_d.st = ST_RESP;
            ST_RESP:    s_d.st = ST_IDLE;
            default:    s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        busy_o      = (s_q.st != ST_IDLE);
        ack_o       = (s_q.st == ST_RESP);
        rsp_err_o   = s_q.reject;
        rsp_abort_o = s_q.abort;
        cyc_stb_o   = (s_q.st == ST_ISSUE);
        cyc_type1_o = type1_w;
        cyc_write_o = s_q.wr;
        ext_we_o    = (s_q.st == ST_MODE) || (s_q.st == ST_RESTORE);
        ext_wdata_o = s_q.saved;
        if (s_q.st == ST_MODE) ext_wdata_o[DW-1:MODE_LSB] = MODE_TYPE1;
    end

    // Tracks whether the current request has issued a strobe.
    logic stb_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                          stb_seen_q <= 1'b0;
        else if (s_q.st == ST_IDLE && req_i) stb_seen_q <= 1'b0;
        else if (cyc_stb_o)                  stb_seen_q <= 1'b1;
    end

    p_reject_no_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && rsp_err_o |-> !stb_seen_q);

    p_mode_before_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_stb_o) && cyc_type1_o |->
            $past(ext_we_o) && ($past(ext_wdata_o[DW-1:MODE_LSB]) == MODE_TYPE1));

    p_restore_before_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && cyc_type1_o && !rsp_err_o |->
            $past(ext_we_o) && ($past(ext_wdata_o[DW-1:MODE_LSB]) == 2'b00));

    p_abort_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && rsp_abort_o && !cyc_write_o |-> (rsp_rdata_o == '1));

    p_ext_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_we_o |-> busy_o);

    p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o && !busy_o);

endmodule

// File: tb/pcicfg_cyc_gen_tb.sv
module pcicfg_cyc_gen_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          TB_W       = 4;
    localparam int          TB_HW      = 40;
    localparam logic [63:0] TB_BASE    = 64'h38_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_i = 1'b0, req_write_i = 1'b0;
    logic [7:0] req_bus_i = '0, req_devfn_i = '0, req_off_i = '0;
    logic [2:0] req_size_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic busy_o, ack_o, rsp_err_o, rsp_abort_o;
    logic [31:0] rsp_rdata_o;
    logic cyc_stb_o, cyc_type1_o, cyc_write_o;
    logic cyc_ack_i = 1'b0, cyc_abort_i = 1'b0;
    logic [TB_HW-1:0] cyc_addr_o;
    logic [31:0] cyc_wdata_o;
    logic [31:0] cyc_rdata_i = '0;
    logic [31:0] ext_val = '0;
    logic ext_we_o;
    logic [31:0] ext_wdata_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcicfg_cyc_gen #(
        .HOST_W(TB_HW), .CFG_BASE(TB_BASE), .MAX_DEV(8), .WAIT_CYCLES(TB_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_write_i(req_write_i),
        .req_bus_i(req_bus_i), .req_devfn_i(req_devfn_i), .req_off_i(req_off_i),
        .req_size_i(req_size_i), .req_wdata_i(req_wdata_i), .busy_o(busy_o),
        .ack_o(ack_o), .rsp_err_o(rsp_err_o), .rsp_abort_o(rsp_abort_o),
        .rsp_rdata_o(rsp_rdata_o), .cyc_stb_o(cyc_stb_o), .cyc_ack_i(cyc_ack_i),
        .cyc_type1_o(cyc_type1_o), .cyc_write_o(cyc_write_o), .cyc_addr_o(cyc_addr_o),
        .cyc_wdata_o(cyc_wdata_o), .cyc_rdata_i(cyc_rdata_i), .cyc_abort_i(cyc_abort_i),
        .ext_rdata_i(ext_val), .ext_we_o(ext_we_o), .ext_wdata_o(ext_wdata_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                           input logic [7:0] off, input logic [2:0] size,
                           input logic [31:0] wdata, input logic [31:0] ext_init,
                           input int abort_at, input bit hold);
        logic [4:0]  dev = devfn[7:3];
        logic [2:0]  fn = devfn[2:0];
        bit          t1 = (bus != 0);
        bit          size_ok = (size == 1) || (size == 2) || (size == 4);
        bit          rej = !size_ok || (!t1 && dev > 8);
        string       atag = t1 ? "R3" : "R1";
        logic [63:0] e_cfg, e_host, a_host, sz_code;
        logic [31:0] pat = {off, devfn, bus, 8'h5A} ^ 32'hC3A5_1E69;
        int          sh = (off % 4) * 8;
        bit          e_abort = !rej && abort_at >= 0 && abort_at <= TB_W;
        int          e_ack = t1 ? TB_W + 2 : TB_W + 1;
        int          idx = -1, cyc = 0, n_stb = 0, n_ext = 0, ack_idx = -100;
        logic [31:0] ext_w0 = '0, ext_w1 = '0, a_wdata = '0, a_rdata = '0;
        int          ext_at0 = -100, ext_at1 = -100;
        bit          busy_ok = 1, got_ack = 0, a_t1 = 0, a_wr = 0, a_err = 0, a_abort = 0;

        if (t1) e_cfg = {40'd0, bus, devfn, off};
        else    e_cfg = (64'd1 << (11 + dev)) + 64'(fn) * 256 + 64'(off);
        sz_code = 64'((int'(size) - 1) * 8);
        e_host  = ((e_cfg * 32) + sz_code + TB_BASE) & ((64'd1 << TB_HW) - 1);
        a_host  = '0;

        ext_val = ext_init;
        @(negedge clk);
        req_i = 1; req_write_i = wr; req_bus_i = bus; req_devfn_i = devfn;
        req_off_i = off; req_size_i = size; req_wdata_i = wdata;
        while (!got_ack && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (hold) begin
                req_write_i = ~req_write_i; req_bus_i = ~req_bus_i;
                req_devfn_i = ~req_devfn_i; req_off_i = req_off_i + 8'd1;
                req_size_i = 3'd3; req_wdata_i = ~req_wdata_i;
            end else begin
                req_i = 0;
            end
            cyc_ack_i = 0; cyc_abort_i = 0;
            if (idx >= 0) idx++;
            if (cyc_stb_o) begin
                if (idx < 0) idx = 0;
                n_stb++;
                a_host = 64'(cyc_addr_o); a_t1 = cyc_type1_o; a_wr = cyc_write_o;
                a_wdata = cyc_wdata_o;
                cyc_ack_i = 1; cyc_rdata_i = pat;
            end
            if (idx >= 0 && idx == abort_at) cyc_abort_i = 1;
            if (ext_we_o) begin
                if (n_ext == 0) begin ext_w0 = ext_wdata_o; ext_at0 = idx; end
                if (n_ext == 1) begin ext_w1 = ext_wdata_o; ext_at1 = idx; end
                n_ext++;
                ext_val = ext_wdata_o;
            end
            if (!busy_o) busy_ok = 0;
            if (ack_o) begin
                got_ack = 1; ack_idx = idx; req_i = 0;
                a_err = rsp_err_o; a_abort = rsp_abort_o; a_rdata = rsp_rdata_o;
            end
        end
        cyc_ack_i = 0; cyc_abort_i = 0;
        chk(got_ack, "R11", "response seen", 64'(got_ack), 64'd1);
        chk(busy_ok, "R11", "busy held until ack", 64'(busy_ok), 64'd1);
        @(negedge clk);
        chk(!busy_o && !ack_o && !cyc_stb_o, "R11", "idle after ack",
            {62'd0, busy_o, ack_o}, 64'd0);

        if (rej) begin
            chk(a_err == 1, size_ok ? "R2" : "R4", "reject flag", 64'(a_err), 64'd1);
            chk(n_stb == 0, size_ok ? "R2" : "R4", "no strobe", 64'(n_stb), 64'd0);
            chk(n_ext == 0, "R7", "no ext write on reject", 64'(n_ext), 64'd0);
            chk(a_abort == 0 && a_rdata == 0, "R2", "reject payload",
                {31'd0, a_abort, a_rdata}, 64'd0);
        end else begin
            chk(a_err == 0, t1 ? "R4" : "R2", "no reject", 64'(a_err), 64'd0);
            chk(n_stb == 1, "R11", "one strobe", 64'(n_stb), 64'd1);
            chk(a_t1 == t1, atag, "type select", 64'(a_t1), 64'(t1));
            chk(((a_host - TB_BASE) >> 5) == e_cfg, atag, "config address",
                (a_host - TB_BASE) >> 5, e_cfg);
            chk(a_host == e_host, "R5", "sparse host address", a_host, e_host);
            chk(a_wr == wr, "R6", "direction", 64'(a_wr), 64'(wr));
            if (wr) begin
                chk(a_wdata == 32'(wdata << sh), "R6", "write lanes",
                    64'(a_wdata), 64'(32'(wdata << sh)));
                chk(a_rdata == 0, "R6", "write response data", 64'(a_rdata), 64'd0);
            end else if (e_abort) begin
                chk(a_rdata == 32'hFFFF_FFFF, "R9", "abort data",
                    64'(a_rdata), 64'hFFFF_FFFF);
            end else begin
                chk(a_rdata == (pat >> sh), "R6", "read alignment",
                    64'(a_rdata), 64'(pat >> sh));
            end
            chk(a_abort == e_abort, "R9", "abort flag", 64'(a_abort), 64'(e_abort));
            chk(ack_idx == e_ack, "R10", "ack timing", 64'(ack_idx), 64'(e_ack));
            if (t1) begin
                chk(n_ext == 2, "R7", "ext write count", 64'(n_ext), 64'd2);
                chk(ext_w0 == ((ext_init & 32'h3FFF_FFFF) | 32'h4000_0000) && ext_at0 == -1,
                    "R7", "mode write", 64'(ext_w0),
                    64'((ext_init & 32'h3FFF_FFFF) | 32'h4000_0000));
                chk(ext_w1 == (ext_init & 32'h3FFF_FFFF) && ext_at1 == TB_W + 1,
                    "R8", "restore write", {32'(ext_at1), ext_w1},
                    {32'(TB_W + 1), ext_init & 32'h3FFF_FFFF});
            end else begin
                chk(n_ext == 0, "R7", "no ext write on type 0", 64'(n_ext), 64'd0);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R11 watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !ack_o && !cyc_stb_o && !ext_we_o, "R11", "reset state",
            {60'd0, busy_o, ack_o, cyc_stb_o, ext_we_o}, 64'd0);

        // Type 0 sweep: every device/function, every size code.
        for (int df = 0; df < 256; df++) begin
            for (int sz = 0; sz < 8; sz++) begin
                run_txn(df[0], 8'd0, 8'(df), 8'((df * 37 + sz * 3) & 255), 3'(sz),
                        32'hA1B2_C3D4 ^ 32'(df * 4099), 32'h0, -1, 0);
            end
        end

        // Type 1 sweep over buses, devfn, lanes and valid sizes.
        for (int b = 0; b < 4; b++) begin
            for (int d = 0; d < 4; d++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int s = 0; s < 3; s++) begin
                        logic [7:0] bv = (b == 0) ? 8'h01 : (b == 1) ? 8'h02 : (b == 2) ? 8'h55 : 8'hFF;
                        logic [7:0] dv = (d == 0) ? 8'h00 : (d == 1) ? 8'h5A : (d == 2) ? 8'hFF : 8'h81;
                        run_txn((o + s) % 2 == 1, bv, dv, 8'(o * 17 + o), 3'(1 << s),
                                32'h0BAD_F00D + 32'(o), 32'hC000_0000 | 32'(b * 4660 + d),
                                -1, 0);
                    end
                end
            end
        end

        // Abort placement: strobe cycle, window cycles, first cycle after window.
        for (int t = 0; t < 2; t++) begin
            for (int a = 0; a <= TB_W + 2; a++) begin
                run_txn(1'b0, t == 1 ? 8'h07 : 8'h00, 8'h1A, 8'h02, 3'd2,
                        32'h0, 32'hFFFF_FFFF, a, 0);
                run_txn(1'b1, t == 1 ? 8'h07 : 8'h00, 8'h1A, 8'h01, 3'd1,
                        32'h0000_00EE, 32'h8123_4567, a, 0);
            end
        end

        // Request inputs toggled while busy must not disturb the transaction.
        run_txn(1'b0, 8'h00, 8'h41, 8'h03, 3'd1, 32'h0, 32'h0, -1, 1);
        run_txn(1'b1, 8'h20, 8'h41, 8'h02, 3'd2, 32'h0000_BEEF, 32'h7FFF_0000, TB_W, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule